// File: doc/BRIEF.md
# Floating-Point Add Issue Interlock

This block sits in the issue stage of an in-order pipeline. It decides, cycle by cycle, whether the add instruction waiting in decode can go to one of the floating-point add units. The add resources are set by parameters: how many identical units there are, how many cycles each unit needs before it can take another operation (its initiation interval), and how many cycles an operation takes to produce its result. Register data hazards are not handled here, because the pipeline forwards every result. The arithmetic is not done here either.

Every unit has its own busy timer. When decode presents a valid add, the block sends it to the lowest-numbered unit whose timer has expired, and raises a dispatch strobe with that unit's index. If every unit is still inside its interval, the block raises a stall. The stall freezes decode, and with it the fetch stage behind decode, until a unit frees up. A fixed number of cycles after each dispatch, the block raises a writeback strobe that carries the same unit index.

Three shapes are supported with the same RTL. The first is one unit taking a new add every second cycle. The second is two units that each take a new add every fourth cycle. The third is a single unit that is fully pipelined.

Top module: `fadd_issue_ctl`

## Requirements
- R1: After reset every unit is free, `issue_stall` and `wb_fire` are 0, and the first request is dispatched at once to unit 0.
- R2: In any cycle, `disp_fire` equals `add_req` AND (some unit free), and `issue_stall` equals `add_req` AND (no unit free). The two are never high together.
- R3: When more than one unit is free, `disp_unit` is the lowest-numbered free unit.
- R4: A unit dispatched in cycle d is not chosen again before cycle d+INIT_IVL. It is free again from cycle d+INIT_IVL on. A stalled request dispatches nothing.
- R5: For every dispatch in cycle d, `wb_fire` is 1 in cycle d+RES_LAT+1 and `wb_unit` equals the unit dispatched in cycle d. In no other cycle is `wb_fire` 1.
- R6: When `add_req` is 0, there is no dispatch and no stall, and the busy state of the units does not change except by counting down.
- R7: With one unit and INIT_IVL=1, every request is dispatched in the cycle it arrives, so `issue_stall` stays 0.
- R8: With two units and INIT_IVL=4, a run of requests goes to unit 0 in cycle d and to unit 1 in cycle d+1. The next request stalls in cycles d+2 and d+3, then goes to unit 0 in cycle d+4, and the one after it goes to unit 1 in cycle d+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| add_req | input | 1 | Decode holds a valid add instruction |
| issue_stall | output | 1 | Hold decode and fetch this cycle |
| disp_fire | output | 1 | The add leaves decode this cycle |
| disp_unit | output | UW | Index of the unit chosen for the dispatch |
| wb_fire | output | 1 | A result is written back this cycle |
| wb_unit | output | UW | Index of the unit whose result is written back |

## Verification
A busy timer that is wrong shows up in the cycle of the next request. A timer that frees too early makes the block dispatch where a stall was due, or pick the wrong unit. A timer that frees too late makes it stall where a dispatch was due. Either way the error is visible within INIT_IVL cycles of the dispatch that loaded the timer. A wrong writeback delay line shows up exactly RES_LAT+1 cycles after the dispatch, as a missing, early, late or mislabelled `wb_fire`. A bad priority order shows up the first time two or more units are free together, which happens right after reset and after any idle gap.

// File: rtl/fadd_ictl_pkg.sv
package fadd_ictl_pkg;

   // limits accepted by the elaboration checks
   localparam int unsigned MAX_UNITS = 16;
   localparam int unsigned MAX_IVL   = 64;
   localparam int unsigned MAX_LAT   = 30;

   // index width that stays at least one bit for a count of one
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fadd_ictl_timer.sv
// Busy timer of one add unit: it holds the cycles left before the unit can
// take another operation.
module fadd_ictl_timer #(
   parameter int unsigned INIT_IVL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic free
);
   localparam int unsigned CW = fadd_ictl_pkg::idx_width(INIT_IVL);

   generate
      if (INIT_IVL < 1) begin : g_bad_ivl
         $error("fadd_ictl_timer: INIT_IVL must be at least 1");
      end

      if (INIT_IVL == 1) begin : g_piped
         // fully pipelined unit: accepts every cycle
         assign free = 1'b1;
      end else begin : g_counted
         localparam logic [CW-1:0] RELOAD = CW'(INIT_IVL - 1);
         logic [CW-1:0] left_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (load) begin
               left_q <= RELOAD;
            end else if (left_q != '0) begin
               left_q <= left_q - 1'b1;
            end
         end

         assign free = (left_q == '0);

         // R4
         busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> !free)
            else $error("unit free right after dispatch");
      end
   endgenerate

   // R4
   no_double_book_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> free)
      else $error("busy unit was dispatched");

endmodule

// File: rtl/fadd_ictl_pick.sv
// Fixed-priority selector: the lowest-numbered free unit wins.
module fadd_ictl_pick #(
   parameter int unsigned N_UNITS = 2,
   localparam int unsigned UW = fadd_ictl_pkg::idx_width(N_UNITS)
) (
   input  logic [N_UNITS-1:0] free_vec,
   output logic               any_free,
   output logic [UW-1:0]      pick_idx
);
   generate
      if (N_UNITS == 1) begin : g_single
         assign any_free = free_vec[0];
         assign pick_idx = '0;
      end else begin : g_multi
         always_comb begin
            any_free = 1'b0;
            pick_idx = '0;
            for (int i = N_UNITS - 1; i >= 0; i--) begin
               if (free_vec[i]) begin
                  any_free = 1'b1;
                  pick_idx = UW'(i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fadd_ictl_wbpipe.sv
// Delay line that turns a dispatch into a writeback strobe STAGES cycles later.
module fadd_ictl_wbpipe #(
   parameter int unsigned STAGES = 4,
   parameter int unsigned UW     = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [UW-1:0] in_u,
   output logic          out_v,
   output logic [UW-1:0] out_u
);
   localparam int unsigned FW = $clog2(STAGES + 2);

   logic [STAGES-1:0] v_q;
   logic [UW-1:0]     u_q [STAGES];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  v_q[k] <= 1'b0;
                  u_q[k] <= '0;
               end else begin
                  v_q[k] <= in_v;
                  u_q[k] <= in_u;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  v_q[k] <= 1'b0;
                  u_q[k] <= '0;
               end else begin
                  v_q[k] <= v_q[k-1];
                  u_q[k] <= u_q[k-1];
               end
            end
         end
      end
   endgenerate

   assign out_v = v_q[STAGES-1];
   assign out_u = u_q[STAGES-1];

   // count of operations between dispatch and writeback
   logic [FW-1:0] inflight_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inflight_q <= '0;
      end else begin
         inflight_q <= inflight_q + FW'(in_v) - FW'(out_v);
      end
   end

   // R5
   wb_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_v |-> (inflight_q != '0))
      else $error("writeback without a dispatch");

   // R5
   inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inflight_q <= FW'(STAGES))
      else $error("more operations in flight than stages");

endmodule

// File: rtl/fadd_issue_ctl.sv
// Issue interlock for a set of floating-point add units.
module fadd_issue_ctl #(
   parameter int unsigned N_UNITS  = 2,
   parameter int unsigned INIT_IVL = 4,
   parameter int unsigned RES_LAT  = 3,
   localparam int unsigned UW = fadd_ictl_pkg::idx_width(N_UNITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add_req,
   output logic          issue_stall,
   output logic          disp_fire,
   output logic [UW-1:0] disp_unit,
   output logic          wb_fire,
   output logic [UW-1:0] wb_unit
);
   localparam int unsigned WB_STAGES = RES_LAT + 1;

   generate
      if (N_UNITS < 1 || N_UNITS > fadd_ictl_pkg::MAX_UNITS) begin : g_bad_units
         $error("fadd_issue_ctl: N_UNITS out of range");
      end
      if (INIT_IVL < 1 || INIT_IVL > fadd_ictl_pkg::MAX_IVL) begin : g_bad_ivl
         $error("fadd_issue_ctl: INIT_IVL out of range");
      end
      if (RES_LAT > fadd_ictl_pkg::MAX_LAT) begin : g_bad_lat
         $error("fadd_issue_ctl: RES_LAT out of range");
      end
   endgenerate

   logic [N_UNITS-1:0] unit_free;
   logic [N_UNITS-1:0] unit_load;
   logic               any_free;
   logic [UW-1:0]      pick_idx;

   generate
      for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
         assign unit_load[u] = disp_fire && (pick_idx == UW'(u));

         fadd_ictl_timer #(
            .INIT_IVL (INIT_IVL)
         ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (unit_load[u]),
            .free  (unit_free[u])
         );
      end
   endgenerate

   fadd_ictl_pick #(
      .N_UNITS (N_UNITS)
   ) u_pick (
      .free_vec (unit_free),
      .any_free (any_free),
      .pick_idx (pick_idx)
   );

   assign disp_fire   = add_req &  any_free;
   assign issue_stall = add_req & ~any_free;
   assign disp_unit   = pick_idx;

   fadd_ictl_wbpipe #(
      .STAGES (WB_STAGES),
      .UW     (UW)
   ) u_wb (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (disp_fire),
      .in_u  (pick_idx),
      .out_v (wb_fire),
      .out_u (wb_unit)
   );

   // R2
   stall_fire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_stall && disp_fire))
      else $error("stall and dispatch together");

   // R6
   idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !add_req |-> (unit_load == '0))
      else $error("unit loaded without a request");

   // R3
   lowest_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_fire |-> (unit_free[disp_unit] &&
                     ((unit_free & ((N_UNITS'(1) << disp_unit) - N_UNITS'(1))) == '0)))
      else $error("dispatch skipped a lower free unit");

   // R4
   one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(unit_load))
      else $error("more than one unit loaded");

endmodule

// File: tb/fadd_issue_ctl_test.sv
// One configuration under test, with its own reference model and stimulus.
module fadd_issue_ctl_cell #(
   parameter int unsigned N_UNITS  = 2,
   parameter int unsigned INIT_IVL = 4,
   parameter int unsigned RES_LAT  = 3,
   parameter int unsigned SEED     = 1,
   parameter int          CYCLES   = 400
) (
   input  logic clk,
   input  logic rst_n,
   output int   n_chk,
   output int   n_fail,
   output logic done
);
   localparam int unsigned UW = fadd_ictl_pkg::idx_width(N_UNITS);

   logic          add_req;
   logic          issue_stall, disp_fire, wb_fire;
   logic [UW-1:0] disp_unit, wb_unit;

   fadd_issue_ctl #(
      .N_UNITS  (N_UNITS),
      .INIT_IVL (INIT_IVL),
      .RES_LAT  (RES_LAT)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .add_req     (add_req),
      .issue_stall (issue_stall),
      .disp_fire   (disp_fire),
      .disp_unit   (disp_unit),
      .wb_fire     (wb_fire),
      .wb_unit     (wb_unit)
   );

   int chk_cnt  = 0;
   int fail_cnt = 0;
   assign n_chk  = chk_cnt;
   assign n_fail = fail_cnt;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int cyc, input int act, input int exp);
      chk_cnt++;
      if (!ok) begin
         fail_cnt++;
         $display("FAIL %s cfg(%0d units, ivl %0d) cycle %0d %s actual=%0d expected=%0d",
                  tag, N_UNITS, INIT_IVL, cyc, what, act, exp);
      end
   endtask

   // cycles each unit still needs before it can take an add again
   int  rem [N_UNITS];
   bit  exp_wb_v [32];
   int  exp_wb_u [32];

   function automatic bit want_req(input int i);
      if (i < 6) return 1'b1;
      return ($urandom % 10) < 7;
   endfunction

   initial begin
      bit r, e_any, e_issue, e_stall;
      int e_u, slot;
      done    = 1'b0;
      add_req = 1'b0;
      for (int u = 0; u < N_UNITS; u++) rem[u] = 0;
      for (int s = 0; s < 32; s++) begin
         exp_wb_v[s] = 1'b0;
         exp_wb_u[s] = 0;
      end
      void'($urandom(SEED));
      wait (rst_n === 1'b1);

      for (int i = 0; i < CYCLES; i++) begin
         @(negedge clk);
         r = want_req(i);
         add_req = r;
         #1;
         e_any = 1'b0;
         e_u   = 0;
         for (int u = N_UNITS - 1; u >= 0; u--) begin
            if (rem[u] == 0) begin
               e_any = 1'b1;
               e_u   = u;
            end
         end
         e_issue = r && e_any;
         e_stall = r && !e_any;

         if (i == 0) begin
            chk(issue_stall == 1'b0, "R1", "stall after reset", i, issue_stall, 0);
            chk(wb_fire == 1'b0, "R1", "writeback after reset", i, wb_fire, 0);
            chk(disp_fire && disp_unit == '0, "R1", "first dispatch unit", i,
                disp_fire ? int'(disp_unit) : -1, 0);
         end

         chk(issue_stall == e_stall, "R2", "stall", i, issue_stall, e_stall);
         if (r) chk(disp_fire == e_issue, "R2", "dispatch", i, disp_fire, e_issue);
         else   chk(disp_fire == 1'b0 && issue_stall == 1'b0, "R6",
                    "activity without request", i, disp_fire | issue_stall, 0);
         if (e_issue) chk(int'(disp_unit) == e_u, "R3", "chosen unit", i, disp_unit, e_u);
         if (e_stall) chk(disp_fire == 1'b0, "R4", "dispatch while all busy", i, disp_fire, 0);
         if (INIT_IVL == 1 && N_UNITS == 1)
            chk(issue_stall == 1'b0, "R7", "pipelined unit stall", i, issue_stall, 0);

         if (N_UNITS == 2 && INIT_IVL == 4) begin
            if (i == 0) chk(disp_fire && disp_unit == 0, "R8", "run head unit", i, disp_unit, 0);
            if (i == 1) chk(disp_fire && disp_unit == 1, "R8", "second add unit", i, disp_unit, 1);
            if (i == 2 || i == 3) chk(issue_stall == 1'b1, "R8", "third add stall", i, issue_stall, 1);
            if (i == 4) chk(disp_fire && disp_unit == 0, "R8", "third add unit", i, disp_unit, 0);
            if (i == 5) chk(disp_fire && disp_unit == 1, "R8", "fourth add unit", i, disp_unit, 1);
         end
         if (N_UNITS == 1 && INIT_IVL == 2) begin
            if (i == 1) chk(issue_stall == 1'b1, "R4", "busy window", i, issue_stall, 1);
            if (i == 2) chk(disp_fire == 1'b1, "R4", "free after window", i, disp_fire, 1);
         end

         slot = i % 32;
         chk(wb_fire == exp_wb_v[slot], "R5", "writeback strobe", i, wb_fire, exp_wb_v[slot]);
         if (exp_wb_v[slot])
            chk(int'(wb_unit) == exp_wb_u[slot], "R5", "writeback unit", i, wb_unit, exp_wb_u[slot]);
         exp_wb_v[slot] = 1'b0;

         for (int u = 0; u < N_UNITS; u++) if (rem[u] > 0) rem[u]--;
         if (e_issue) begin
            rem[e_u] = INIT_IVL - 1;
            exp_wb_v[(i + RES_LAT + 1) % 32] = 1'b1;
            exp_wb_u[(i + RES_LAT + 1) % 32] = e_u;
         end
      end
      @(negedge clk);
      add_req = 1'b0;
      done = 1'b1;
   end

endmodule

module fadd_issue_ctl_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int   c0, f0, c1, f1, c2, f2;
   logic d0, d1, d2;

   fadd_issue_ctl_cell #(.N_UNITS(2), .INIT_IVL(4), .RES_LAT(3), .SEED(11)) c_dual (
      .clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .done(d0));
   fadd_issue_ctl_cell #(.N_UNITS(1), .INIT_IVL(2), .RES_LAT(3), .SEED(23)) c_single (
      .clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .done(d1));
   fadd_issue_ctl_cell #(.N_UNITS(1), .INIT_IVL(1), .RES_LAT(3), .SEED(37)) c_piped (
      .clk(clk), .rst_n(rst_n), .n_chk(c2), .n_fail(f2), .done(d2));

   initial begin
      int waited = 0;
      int wd_fail = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && waited < WATCHDOG) begin
         @(posedge clk);
         waited++;
      end
      if (waited >= WATCHDOG) begin
         wd_fail = 1;
         $display("FAIL watchdog run did not end actual=%0d expected<%0d", waited, WATCHDOG);
      end
      #1;
      $display("TB_RESULT checks=%0d failures=%0d", c0 + c1 + c2 + wd_fail, f0 + f1 + f2 + wd_fail);
      $finish;
   end

endmodule